// File: doc/BRIEF.md
# SMBus Host Register File

This block is the programmer-visible face of an SMBus host controller. A CPU reaches it over a simple byte bus: an address, a write strobe, a read strobe and an 8-bit data path. Behind it, a separate transaction engine moves bits on the wire. The register file holds the transaction set-up: target address, command byte, two data bytes, a PEC byte and an auxiliary mode byte. It turns a control-register write into a one-cycle start request, and it offers a kill control that aborts the running transfer.

Events reported by the engine are gathered into a sticky status byte. These are completion, byte completion, missing acknowledge, lost arbitration and alert. Software clears each status bit by writing one to it. A busy flag tracks the transfer from start to finish and cannot be written. An in-use flag works as a software semaphore. Reading the control register also sends a pulse to the block-buffer index logic, which lives outside this block.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, and `irq`, `eng_start` and `blk_idx_rst` are low.
- R2: Offsets 3 (command), 4 (target address), 5 (data 0), 6 (data 1) and 8 (PEC) read back the last byte written and drive `eng_cmd`, `eng_slv_addr`, `eng_data0`, `eng_data1` and `eng_pec_val`. Offset 13 (auxiliary control) keeps bits 1:0 only; bits 7:2 read 0. Every other offset, including block data (7) and auxiliary status (12), reads 0x00 and ignores writes.
- R3: The status byte at offset 0 has this layout: bit 7 byte-done, bit 6 in-use, bit 5 alert, bit 4 failed, bit 3 lost arbitration, bit 2 no acknowledge, bit 1 transaction complete, bit 0 busy. Engine event pulses `eng_byte_done`, `eng_alert`, `eng_bus_err`, `eng_dev_err` and `eng_done` set their bits one cycle later, and the bits stay set.
- R4: Writing 1 to any of status bits 7:1 clears that bit, and writing 0 leaves it alone. Busy (bit 0) ignores writes. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: The control register at offset 2 holds PEC enable (bit 7), protocol (bits 5:2) and kill (bit 1); bits 6 and 0 read 0. A write with bit 6 set, bit 1 clear and busy low is a start: in the next cycle `eng_start` is high for exactly one cycle, busy is set, and `eng_proto` and `eng_pec_en` carry the written fields. A start write with bit 1 set stores its fields but starts nothing.
- R6: A control write with bit 6 set while busy is high changes no register and produces no `eng_start`.
- R7: An `eng_done` pulse clears busy and sets the transaction-complete bit.
- R8: `eng_kill` follows stored control bit 1. While that bit is set and busy is high, the next cycle has busy clear and failed set. Kill with busy low sets nothing.
- R9: A read strobe at offset 2 raises `blk_idx_rst` for one cycle, in the cycle after the strobe. Reads at other offsets do not raise it.
- R10: A read of the status register returns its current value, and afterwards sets in-use (bit 6).
- R11: `irq` is high exactly when at least one of the complete, failed, lost-arbitration or no-acknowledge bits is set. Alert, byte-done and in-use do not raise it.
- R12: `eng_rd_we` loads `eng_rd_d0` into data 0 and `eng_rd_d1` into data 1. If a CPU write to those registers happens in the same cycle, the engine value is kept.
- R13: Auxiliary control bit 0 drives `eng_crc_en` and bit 1 drives `eng_blkbuf_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_kill | output | 1 | Abort level to the engine |
| eng_proto | output | 4 | Protocol selection |
| eng_pec_en | output | 1 | Append/check PEC for this transfer |
| eng_crc_en | output | 1 | Hardware CRC mode (aux bit 0) |
| eng_blkbuf_en | output | 1 | 32-byte buffer mode (aux bit 1) |
| eng_cmd | output | 8 | Command byte |
| eng_slv_addr | output | 8 | Target address and direction byte |
| eng_data0 | output | 8 | Data 0 |
| eng_data1 | output | 8 | Data 1 |
| eng_pec_val | output | 8 | PEC byte |
| eng_done | input | 1 | Transfer complete pulse |
| eng_byte_done | input | 1 | Byte complete pulse |
| eng_dev_err | input | 1 | No-acknowledge pulse |
| eng_bus_err | input | 1 | Lost-arbitration pulse |
| eng_alert | input | 1 | Alert pulse |
| eng_rd_we | input | 1 | Load read-back data into data 0/1 |
| eng_rd_d0 | input | 8 | Read-back byte for data 0 |
| eng_rd_d1 | input | 8 | Read-back byte for data 1 |
| blk_idx_rst | output | 1 | Block-buffer index reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: `ADDR_W` = 4 and `AUX_W` = 2. With a 4-bit offset, the whole 16-byte window can be reached, so the unmapped offsets (1, 7, 9 to 12, 14, 15) can be shown to read zero and to ignore writes. A 2-bit auxiliary field means the upper six bits of offset 13 can be shown to be dropped. The same build is used to collide engine events with software clears and engine read-back with CPU writes in a single cycle. It also runs start, kill and completion against the busy flag.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  localparam int BYTE_W = 8;

  // register offsets
  localparam int OFS_STS = 0;
  localparam int OFS_CTL = 2;
  localparam int OFS_CMD = 3;
  localparam int OFS_ADR = 4;
  localparam int OFS_D0  = 5;
  localparam int OFS_D1  = 6;
  localparam int OFS_PEC = 8;
  localparam int OFS_AXC = 13;

  // status bit positions
  localparam int ST_BUSY     = 0;
  localparam int ST_INTR     = 1;
  localparam int ST_DEVERR   = 2;
  localparam int ST_BUSERR   = 3;
  localparam int ST_FAILED   = 4;
  localparam int ST_ALERT    = 5;
  localparam int ST_INUSE    = 6;
  localparam int ST_BYTEDONE = 7;

  localparam logic [BYTE_W-1:0] STS_W1C = 8'hFE;
  localparam logic [BYTE_W-1:0] STS_IRQ = 8'h1E;

  // control bit positions
  localparam int CTL_KILL = 1;
  localparam int CTL_PLO  = 2;
  localparam int CTL_PHI  = 5;
  localparam int CTL_GO   = 6;
  localparam int CTL_PEC  = 7;
  localparam int PROTO_W  = CTL_PHI - CTL_PLO + 1;

  typedef struct packed {
    logic               pec_en;
    logic [PROTO_W-1:0] proto;
    logic               kill;
  } ctl_t;

  // sticky update: clear where requested, then set where an event fired
  function automatic logic [BYTE_W-1:0] sticky_next(input logic [BYTE_W-1:0] cur,
                                                    input logic [BYTE_W-1:0] set_v,
                                                    input logic [BYTE_W-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  function automatic logic [BYTE_W-1:0] ctl_to_byte(input ctl_t c);
    return {c.pec_en, 1'b0, c.proto, c.kill, 1'b0};
  endfunction

  function automatic logic irq_of(input logic [BYTE_W-1:0] sts);
    return |(sts & STS_IRQ);
  endfunction

endpackage

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sts,
  input  logic [BYTE_W-1:0] clr_req,
  input  logic              rd_sts,
  input  logic              start_acc,
  input  logic              kill_q,
  input  logic              ev_done,
  input  logic              ev_byte,
  input  logic              ev_dev,
  input  logic              ev_bus,
  input  logic              ev_alert,
  output logic [BYTE_W-1:0] sts_q
);

  logic              busy;
  logic              kill_hit;
  logic              busy_n;
  logic [BYTE_W-1:0] set_v;
  logic [BYTE_W-1:0] clr_v;
  logic [BYTE_W-1:0] flags_n;

  assign busy     = sts_q[ST_BUSY];
  assign kill_hit = kill_q && busy;

  always_comb begin
    set_v              = '0;
    set_v[ST_BYTEDONE] = ev_byte;
    set_v[ST_INUSE]    = rd_sts;
    set_v[ST_ALERT]    = ev_alert;
    set_v[ST_FAILED]   = kill_hit;
    set_v[ST_BUSERR]   = ev_bus;
    set_v[ST_DEVERR]   = ev_dev;
    set_v[ST_INTR]     = ev_done;
    clr_v              = wr_sts ? (clr_req & STS_W1C) : '0;
    busy_n             = busy;
    if (start_acc)                busy_n = 1'b1;
    else if (ev_done || kill_hit) busy_n = 1'b0;
    flags_n          = sticky_next(sts_q, set_v, clr_v);
    flags_n[ST_BUSY] = busy_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= flags_n;
  end

  assert_start_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> sts_q[ST_BUSY]);

  assert_kill_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_hit |=> (!sts_q[ST_BUSY] && sts_q[ST_FAILED]));

  assert_w1c_intr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v[ST_INTR] && !ev_done) |=> !sts_q[ST_INTR]);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_acc && !ev_done && !kill_hit) |=> $stable(sts_q[ST_BUSY]));

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !start_acc) |=> (!sts_q[ST_BUSY] && sts_q[ST_INTR]));

endmodule

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
  import smb_host_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic rd_ctl,
  input  logic go_bit,
  input  ctl_t wr_fields,
  input  logic busy,
  output ctl_t ctl_q,
  output logic start_acc,
  output logic eng_start,
  output logic blk_idx_rst
);

  logic start_req;
  logic start_drop;
  logic upd;

  assign start_req  = wr_ctl && go_bit;
  assign start_drop = start_req && busy;
  assign start_acc  = start_req && !busy && !wr_fields.kill;
  assign upd        = wr_ctl && !start_drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      eng_start   <= 1'b0;
      blk_idx_rst <= 1'b0;
    end else begin
      if (upd) ctl_q <= wr_fields;
      eng_start   <= start_acc;
      blk_idx_rst <= rd_ctl;
    end
  end

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> ($stable(ctl_q) && !eng_start));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_idx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |=> blk_idx_rst);

endmodule

// File: rtl/smb_host_data.sv
module smb_host_data
  import smb_host_pkg::*;
#(
  parameter int AUX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_adr,
  input  logic              wr_pec,
  input  logic              wr_d0,
  input  logic              wr_d1,
  input  logic              wr_axc,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              eng_rd_we,
  input  logic [BYTE_W-1:0] eng_rd_d0,
  input  logic [BYTE_W-1:0] eng_rd_d1,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] adr_q,
  output logic [BYTE_W-1:0] pec_q,
  output logic [BYTE_W-1:0] d0_q,
  output logic [BYTE_W-1:0] d1_q,
  output logic [AUX_W-1:0]  axc_q
);

  localparam int NPLAIN = 3;
  localparam int NRES   = 2;

  logic [NPLAIN-1:0]             plain_we;
  logic [NPLAIN-1:0][BYTE_W-1:0] plain_q;
  logic [NRES-1:0]               res_we;
  logic [NRES-1:0][BYTE_W-1:0]   res_eng;
  logic [NRES-1:0][BYTE_W-1:0]   res_q;

  assign plain_we = {wr_pec, wr_adr, wr_cmd};
  assign res_we   = {wr_d1, wr_d0};
  assign res_eng  = {eng_rd_d1, eng_rd_d0};

  // CPU-only byte registers
  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)           q <= '0;
      else if (plain_we[g]) q <= wdata;
    end
    assign plain_q[g] = q;
  end

  // result registers: engine read-back beats a CPU write
  for (genvar g = 0; g < NRES; g++) begin : g_res
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)         q <= '0;
      else if (eng_rd_we) q <= res_eng[g];
      else if (res_we[g]) q <= wdata;
    end
    assign res_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      axc_q <= '0;
    else if (wr_axc) axc_q <= wdata[AUX_W-1:0];
  end

  assign cmd_q = plain_q[0];
  assign adr_q = plain_q[1];
  assign pec_q = plain_q[2];
  assign d0_q  = res_q[0];
  assign d1_q  = res_q[1];

  assert_eng_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rd_we |=> (d0_q == $past(eng_rd_d0) && d1_q == $past(eng_rd_d1)));

  assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (cmd_q == $past(wdata)));

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AUX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              eng_start,
  output logic              eng_kill,
  output logic [3:0]        eng_proto,
  output logic              eng_pec_en,
  output logic              eng_crc_en,
  output logic              eng_blkbuf_en,
  output logic [7:0]        eng_cmd,
  output logic [7:0]        eng_slv_addr,
  output logic [7:0]        eng_data0,
  output logic [7:0]        eng_data1,
  output logic [7:0]        eng_pec_val,
  input  logic              eng_done,
  input  logic              eng_byte_done,
  input  logic              eng_dev_err,
  input  logic              eng_bus_err,
  input  logic              eng_alert,
  input  logic              eng_rd_we,
  input  logic [7:0]        eng_rd_d0,
  input  logic [7:0]        eng_rd_d1,
  output logic              blk_idx_rst,
  output logic              irq
);

  localparam int AUX_PAD = BYTE_W - AUX_W;

  // address decode
  logic hit_sts, hit_ctl, hit_cmd, hit_adr, hit_d0, hit_d1, hit_pec, hit_axc;
  assign hit_sts = (bus_addr == ADDR_W'(OFS_STS));
  assign hit_ctl = (bus_addr == ADDR_W'(OFS_CTL));
  assign hit_cmd = (bus_addr == ADDR_W'(OFS_CMD));
  assign hit_adr = (bus_addr == ADDR_W'(OFS_ADR));
  assign hit_d0  = (bus_addr == ADDR_W'(OFS_D0));
  assign hit_d1  = (bus_addr == ADDR_W'(OFS_D1));
  assign hit_pec = (bus_addr == ADDR_W'(OFS_PEC));
  assign hit_axc = (bus_addr == ADDR_W'(OFS_AXC));

  logic              rd_sts, rd_ctl, wr_sts, wr_ctl;
  logic [BYTE_W-1:0] sts_q;
  ctl_t              ctl_q;
  ctl_t              wr_fields;
  logic              start_acc;
  logic [BYTE_W-1:0] cmd_q, adr_q, pec_q, d0_q, d1_q;
  logic [AUX_W-1:0]  axc_q;

  assign rd_sts    = bus_rd && hit_sts;
  assign rd_ctl    = bus_rd && hit_ctl;
  assign wr_sts    = bus_wr && hit_sts;
  assign wr_ctl    = bus_wr && hit_ctl;
  assign wr_fields = ctl_t'{bus_wdata[CTL_PEC], bus_wdata[CTL_PHI:CTL_PLO], bus_wdata[CTL_KILL]};

  smb_host_status u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sts    (wr_sts),
    .clr_req   (bus_wdata),
    .rd_sts    (rd_sts),
    .start_acc (start_acc),
    .kill_q    (ctl_q.kill),
    .ev_done   (eng_done),
    .ev_byte   (eng_byte_done),
    .ev_dev    (eng_dev_err),
    .ev_bus    (eng_bus_err),
    .ev_alert  (eng_alert),
    .sts_q     (sts_q)
  );

  smb_host_ctrl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctl      (wr_ctl),
    .rd_ctl      (rd_ctl),
    .go_bit      (bus_wdata[CTL_GO]),
    .wr_fields   (wr_fields),
    .busy        (sts_q[ST_BUSY]),
    .ctl_q       (ctl_q),
    .start_acc   (start_acc),
    .eng_start   (eng_start),
    .blk_idx_rst (blk_idx_rst)
  );

  smb_host_data #(.AUX_W(AUX_W)) u_dat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (bus_wr && hit_cmd),
    .wr_adr    (bus_wr && hit_adr),
    .wr_pec    (bus_wr && hit_pec),
    .wr_d0     (bus_wr && hit_d0),
    .wr_d1     (bus_wr && hit_d1),
    .wr_axc    (bus_wr && hit_axc),
    .wdata     (bus_wdata),
    .eng_rd_we (eng_rd_we),
    .eng_rd_d0 (eng_rd_d0),
    .eng_rd_d1 (eng_rd_d1),
    .cmd_q     (cmd_q),
    .adr_q     (adr_q),
    .pec_q     (pec_q),
    .d0_q      (d0_q),
    .d1_q      (d1_q),
    .axc_q     (axc_q)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_sts) bus_rdata = sts_q;
    if (hit_ctl) bus_rdata = ctl_to_byte(ctl_q);
    if (hit_cmd) bus_rdata = cmd_q;
    if (hit_adr) bus_rdata = adr_q;
    if (hit_d0)  bus_rdata = d0_q;
    if (hit_d1)  bus_rdata = d1_q;
    if (hit_pec) bus_rdata = pec_q;
    if (hit_axc) bus_rdata = {{AUX_PAD{1'b0}}, axc_q};
  end

  assign eng_kill      = ctl_q.kill;
  assign eng_proto     = ctl_q.proto;
  assign eng_pec_en    = ctl_q.pec_en;
  assign eng_crc_en    = axc_q[0];
  assign eng_blkbuf_en = axc_q[1];
  assign eng_cmd       = cmd_q;
  assign eng_slv_addr  = adr_q;
  assign eng_data0     = d0_q;
  assign eng_data1     = d1_q;
  assign eng_pec_val   = pec_q;
  assign irq           = irq_of(sts_q);

  assert_alert_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_alert && !irq && !eng_done && !eng_dev_err && !eng_bus_err && !ctl_q.kill) |=> !irq);

endmodule

// File: tb/sim_smb_host_regs.sv
module sim_smb_host_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       eng_start, eng_kill, eng_pec_en, eng_crc_en, eng_blkbuf_en;
  logic [3:0] eng_proto;
  logic [7:0] eng_cmd, eng_slv_addr, eng_data0, eng_data1, eng_pec_val;
  logic       eng_done = 1'b0, eng_byte_done = 1'b0, eng_dev_err = 1'b0;
  logic       eng_bus_err = 1'b0, eng_alert = 1'b0, eng_rd_we = 1'b0;
  logic [7:0] eng_rd_d0 = '0, eng_rd_d1 = '0;
  logic       blk_idx_rst, irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  over   = 1'b0;

  always #2 clk = ~clk;

  smb_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_kill(eng_kill),
    .eng_proto(eng_proto), .eng_pec_en(eng_pec_en), .eng_crc_en(eng_crc_en),
    .eng_blkbuf_en(eng_blkbuf_en), .eng_cmd(eng_cmd), .eng_slv_addr(eng_slv_addr),
    .eng_data0(eng_data0), .eng_data1(eng_data1), .eng_pec_val(eng_pec_val),
    .eng_done(eng_done), .eng_byte_done(eng_byte_done), .eng_dev_err(eng_dev_err),
    .eng_bus_err(eng_bus_err), .eng_alert(eng_alert), .eng_rd_we(eng_rd_we),
    .eng_rd_d0(eng_rd_d0), .eng_rd_d1(eng_rd_d1), .blk_idx_rst(blk_idx_rst), .irq(irq)
  );

  // vector: {op, offset, data, expected}; op 1 = write, 2 = read and compare
  localparam int NV = 32;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 4'd3,  8'hA5, 8'h00}, {2'd2, 4'd3,  8'h00, 8'hA5},
    {2'd1, 4'd4,  8'h5A, 8'h00}, {2'd2, 4'd4,  8'h00, 8'h5A},
    {2'd1, 4'd5,  8'h3C, 8'h00}, {2'd2, 4'd5,  8'h00, 8'h3C},
    {2'd1, 4'd6,  8'hC3, 8'h00}, {2'd2, 4'd6,  8'h00, 8'hC3},
    {2'd1, 4'd8,  8'h81, 8'h00}, {2'd2, 4'd8,  8'h00, 8'h81},
    {2'd1, 4'd13, 8'hFF, 8'h00}, {2'd2, 4'd13, 8'h00, 8'h03},
    {2'd1, 4'd13, 8'h00, 8'h00}, {2'd2, 4'd13, 8'h00, 8'h00},
    {2'd1, 4'd7,  8'h77, 8'h00}, {2'd2, 4'd7,  8'h00, 8'h00},
    {2'd2, 4'd12, 8'h00, 8'h00}, {2'd1, 4'd1,  8'h55, 8'h00},
    {2'd2, 4'd1,  8'h00, 8'h00}, {2'd1, 4'd15, 8'hAA, 8'h00},
    {2'd2, 4'd15, 8'h00, 8'h00}, {2'd2, 4'd0,  8'h00, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h40}, {2'd1, 4'd0,  8'h40, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h00}, {2'd1, 4'd0,  8'hFF, 8'h00},
    {2'd1, 4'd2,  8'hA4, 8'h00}, {2'd2, 4'd2,  8'h00, 8'hA4},
    {2'd1, 4'd2,  8'h80, 8'h00}, {2'd2, 4'd2,  8'h00, 8'h80},
    {2'd1, 4'd2,  8'h00, 8'h00}, {2'd2, 4'd2,  8'h00, 8'h00}
  };

  function automatic string req_of(input logic [3:0] ofs);
    if (ofs == 4'd0) return "R10";
    if (ofs == 4'd2) return "R5";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!over) begin
      n_fail++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 eng_start", {7'd0, eng_start}, 8'h00);
    chk("R1 blk_idx_rst", {7'd0, blk_idx_rst}, 8'h00);
    rd_chk("R1 ctl", 4'd2, 8'h00);
    rd_chk("R1 d0", 4'd5, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21:20] == 2'd1) wr(VEC[i][19:16], VEC[i][15:8]);
      else rd_chk(req_of(VEC[i][19:16]), VEC[i][19:16], VEC[i][7:0]);
    end
    chk("R2 eng_cmd", eng_cmd, 8'hA5);
    chk("R2 eng_slv_addr", eng_slv_addr, 8'h5A);
    chk("R2 eng_pec_val", eng_pec_val, 8'h81);

    // R5 start
    wr(4'd2, 8'hEC);
    chk("R5 eng_start", {7'd0, eng_start}, 8'h01);
    chk("R5 eng_proto", {4'd0, eng_proto}, 8'h0B);
    chk("R5 eng_pec_en", {7'd0, eng_pec_en}, 8'h01);
    rd_chk("R5 busy", 4'd0, 8'h01);
    chk("R5 one-cycle start", {7'd0, eng_start}, 8'h00);
    rd_chk("R5 go bit reads 0", 4'd2, 8'hAC);
    chk("R9 pulse after ctl read", {7'd0, blk_idx_rst}, 8'h01);
    rd_chk("R10 in-use set", 4'd0, 8'h41);
    chk("R9 no pulse on sts read", {7'd0, blk_idx_rst}, 8'h00);

    // R6 start while busy; R4 busy not writable
    wr(4'd2, 8'h44);
    chk("R6 eng_start", {7'd0, eng_start}, 8'h00);
    rd_chk("R6 ctl unchanged", 4'd2, 8'hAC);
    wr(4'd0, 8'h01);
    rd_chk("R4 busy read-only", 4'd0, 8'h41);

    // R7 completion, R11 irq, R4 clear
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    chk("R11 irq on complete", {7'd0, irq}, 8'h01);
    rd_chk("R7 done", 4'd0, 8'h42);
    wr(4'd0, 8'h02);
    rd_chk("R4 clear intr", 4'd0, 8'h40);
    chk("R11 irq low", {7'd0, irq}, 8'h00);
    wr(4'd0, 8'h40);
    rd_chk("R10 in-use cleared", 4'd0, 8'h00);
    wr(4'd0, 8'h40);

    // R3 events, R4 selective clear
    @(negedge clk);
    eng_byte_done = 1'b1; eng_dev_err = 1'b1; eng_bus_err = 1'b1; eng_alert = 1'b1;
    @(negedge clk);
    eng_byte_done = 1'b0; eng_dev_err = 1'b0; eng_bus_err = 1'b0; eng_alert = 1'b0;
    chk("R11 irq on errors", {7'd0, irq}, 8'h01);
    rd_chk("R3 events", 4'd0, 8'hAC);
    wr(4'd0, 8'h04);
    rd_chk("R4 write 0 keeps", 4'd0, 8'hE8);
    wr(4'd0, 8'hFF);
    rd_chk("R4 clear all", 4'd0, 8'h00);
    wr(4'd0, 8'h40);
    @(negedge clk); eng_alert = 1'b1;
    @(negedge clk); eng_alert = 1'b0;
    chk("R11 alert no irq", {7'd0, irq}, 8'h00);
    rd_chk("R3 alert", 4'd0, 8'h20);
    wr(4'd0, 8'h60);

    // R4 event beats clear in same cycle
    @(negedge clk);
    bus_addr = 4'd0; bus_wdata = 8'h04; bus_wr = 1'b1; eng_dev_err = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_dev_err = 1'b0;
    rd_chk("R4 set wins", 4'd0, 8'h04);
    wr(4'd0, 8'h44);

    // R8 kill
    wr(4'd2, 8'h40);
    chk("R5 start again", {7'd0, eng_start}, 8'h01);
    wr(4'd2, 8'h02);
    chk("R8 eng_kill", {7'd0, eng_kill}, 8'h01);
    rd_chk("R8 abort", 4'd0, 8'h10);
    chk("R11 irq on failed", {7'd0, irq}, 8'h01);
    wr(4'd0, 8'h50);
    wr(4'd2, 8'h42);
    chk("R5 kill blocks start", {7'd0, eng_start}, 8'h00);
    rd_chk("R8 idle kill", 4'd0, 8'h00);
    wr(4'd0, 8'h40);
    wr(4'd2, 8'h00);

    // R12 engine read-back beats CPU write
    @(negedge clk);
    bus_addr = 4'd5; bus_wdata = 8'h11; bus_wr = 1'b1;
    eng_rd_we = 1'b1; eng_rd_d0 = 8'h99; eng_rd_d1 = 8'h66;
    @(negedge clk);
    bus_wr = 1'b0; eng_rd_we = 1'b0;
    chk("R12 eng_data0", eng_data0, 8'h99);
    rd_chk("R12 d0", 4'd5, 8'h99);
    rd_chk("R12 d1", 4'd6, 8'h66);
    chk("R12 eng_data1", eng_data1, 8'h66);

    // R13 aux outputs
    wr(4'd13, 8'h01);
    chk("R13 crc", {6'd0, eng_blkbuf_en, eng_crc_en}, 8'h01);
    wr(4'd13, 8'h02);
    chk("R13 blkbuf", {6'd0, eng_blkbuf_en, eng_crc_en}, 8'h02);

    over = 1'b1;
    summary();
    $finish;
  end

endmodule